// File: doc/BRIEF.md
# External Event Timestamp Capture Unit

This block records the value of a 32-bit free-running time base at the moment a trigger occurs. The trigger is either an edge on an asynchronous external event-request pin or a pulse from an internal periodic tick generator. Software picks the source, the edge polarity and two control bits through a small word-wide register port. It reads a status word and then the captured timestamp as a low and a high half-word.

Capture is single-shot. A successful capture raises a valid flag, and further events are refused until software clears that flag. An event that arrives while a capture is still unread raises a sticky error flag. If the overwrite control bit is set, such an event also replaces the stored timestamp. A saturating capture count in the status word counts accepted captures while the count-start bit is set, and any write to the configuration or status register resets it to zero.

Top module: `evt_stamp_unit`

## Requirements
- R1: After reset, all four readable registers (configuration, status, timestamp low, timestamp high) read as zero.
- R2: With the external source and rising-edge mode, a 0-to-1 change on `evt_in` captures the `time_in` value present during the cycle that follows the second rising clock edge after the change (two synchronizer stages), and sets valid (status bit 0).
- R3: Configuration bit 0 set to 1 selects falling-edge capture. In either mode, the opposite edge of `evt_in` causes no capture.
- R4: Status bit 2 set to 1 selects the internal tick, which causes a capture every `PULSE_PERIOD` cycles. When status bit 2 is 0, the tick causes no capture.
- R5: While valid is set and the overwrite bit (configuration bit 1) is 0, further events leave the stored timestamp unchanged.
- R6: An event that arrives while valid is set raises the error flag (status bit 1). The flag stays set until a status write with bit 1 equal to 0; a status write with bit 1 equal to 1 keeps it.
- R7: With the overwrite bit set, an event that arrives while valid is set replaces the stored timestamp and counts as a capture.
- R8: The capture count (status bits 8 and up, `CNT_W` bits wide) increments on each accepted capture while configuration bit 2 is 1, saturates at 2^CNT_W-1, and does not change while configuration bit 2 is 0.
- R9: Any write to the configuration or status register clears the capture count.
- R10: A status write with bit 0 equal to 0 clears valid. A write with bit 0 equal to 1 never sets it.
- R11: The read map is address 0 configuration (the whole written word reads back), 1 status, 2 timestamp bits 15:0, 3 timestamp bits 31:16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| time_in | input | TS_W | Free-running time base to be latched |
| evt_in | input | 1 | Asynchronous external event request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | WORD_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | WORD_W | Register read data (combinational) |

## Verification
The hardest situation to reach is an event that lands while an earlier capture is still unread. The case must be reached both with and without overwrite, and it must be separated from an event that is merely ignored because of its polarity. The bench reaches it by toggling `evt_in` with enough settling time for the synchronizer, without clearing valid in between, and then inspecting the timestamp, the error flag and the count. Saturation of the count needs many accepted captures without any register write. The bench gets them by running the internal tick in overwrite mode for more than 2^CNT_W periods.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;
   localparam logic [1:0] A_CFG   = 2'd0;
   localparam logic [1:0] A_STS   = 2'd1;
   localparam logic [1:0] A_TS_LO = 2'd2;
   localparam logic [1:0] A_TS_HI = 2'd3;

   // configuration word bit positions
   localparam int CFG_FALL  = 0;
   localparam int CFG_OVW   = 1;
   localparam int CFG_START = 2;

   // status word bit positions
   localparam int STS_VALID = 0;
   localparam int STS_ERR   = 1;
   localparam int STS_SRC   = 2;
   localparam int STS_CNT   = 8;
endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   input  logic fall_sel,
   output logic edge_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("evt_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) chain_q[0] <= 1'b0;
            else     chain_q[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) chain_q[i] <= 1'b0;
            else     chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= chain_q[STAGES-1];
   end

   always_comb begin
      if (fall_sel) edge_o = prev_q & ~chain_q[STAGES-1];
      else          edge_o = chain_q[STAGES-1] & ~prev_q;
   end

   a_r3_edge_after_change: assert property (@(posedge clk) disable iff (rst)
      edge_o |-> (chain_q[STAGES-1] != prev_q));
endmodule

// File: rtl/evt_tick_gen.sv
module evt_tick_gen #(
   parameter int PERIOD = 1000
) (
   input  logic clk,
   input  logic rst,
   output logic tick_o
);
   if (PERIOD < 2) begin : g_bad_period
      $error("evt_tick_gen: PERIOD must be at least 2");
   end

   localparam int DW = $clog2(PERIOD);
   localparam logic [DW-1:0] LAST = DW'(PERIOD - 1);

   logic [DW-1:0] div_q;
   logic          tick_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         div_q  <= '0;
         tick_q <= 1'b0;
      end else begin
         div_q  <= (div_q == LAST) ? '0 : div_q + 1'b1;
         tick_q <= (div_q == LAST);
      end
   end

   assign tick_o = tick_q;

   a_r4_tick_isolated: assert property (@(posedge clk) disable iff (rst)
      tick_o |=> !tick_o);
endmodule

// File: rtl/evt_capture_core.sv
module evt_capture_core #(
   parameter int TS_W  = 32,
   parameter int CNT_W = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            evt,
   input  logic [TS_W-1:0] time_in,
   input  logic            ovw_en,
   input  logic            cnt_en,
   input  logic            cnt_clr,
   input  logic            sts_wr,
   input  logic            keep_valid,
   input  logic            keep_err,
   output logic            valid_o,
   output logic            err_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic [TS_W-1:0] ts_o
);
   if (CNT_W < 1) begin : g_bad_cnt
      $error("evt_capture_core: CNT_W must be at least 1");
   end

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             valid_q, err_q;
   logic [CNT_W-1:0] cnt_q;
   logic [TS_W-1:0]  ts_q;
   logic             accept, miss;
   logic             valid_n, err_n;
   logic [CNT_W-1:0] cnt_n;

   assign accept = evt & (~valid_q | ovw_en);
   assign miss   = evt & valid_q;

   always_comb begin
      valid_n = sts_wr ? (valid_q & keep_valid) : valid_q;
      if (accept) valid_n = 1'b1;
      err_n = sts_wr ? (err_q & keep_err) : err_q;
      if (miss) err_n = 1'b1;
      cnt_n = cnt_clr ? '0 : cnt_q;
      if (accept && cnt_en && (cnt_n != CNT_MAX)) cnt_n = cnt_n + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
         err_q   <= 1'b0;
         cnt_q   <= '0;
         ts_q    <= '0;
      end else begin
         valid_q <= valid_n;
         err_q   <= err_n;
         cnt_q   <= cnt_n;
         if (accept) ts_q <= time_in;
      end
   end

   assign valid_o = valid_q;
   assign err_o   = err_q;
   assign cnt_o   = cnt_q;
   assign ts_o    = ts_q;

   // R2: a fresh capture holds the time base of the previous cycle
   a_r2_capture_value: assert property (@(posedge clk) disable iff (rst)
      $rose(valid_q) |-> (ts_q == $past(time_in)));
   // R10: valid only rises because of an event
   a_r10_valid_source: assert property (@(posedge clk) disable iff (rst)
      $rose(valid_q) |-> $past(evt));
   a_r5_hold_ts: assert property (@(posedge clk) disable iff (rst)
      (valid_q && !ovw_en) |=> (ts_q == $past(ts_q)));
   a_r6_err_cause: assert property (@(posedge clk) disable iff (rst)
      $rose(err_q) |-> ($past(evt) && $past(valid_q)));
   a_r8_cnt_monotonic: assert property (@(posedge clk) disable iff (rst)
      !$past(cnt_clr) |-> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/evt_stamp_unit.sv
module evt_stamp_unit
   import evt_stamp_pkg::*;
#(
   parameter int TS_W         = 32,
   parameter int WORD_W       = 16,
   parameter int CNT_W        = 4,
   parameter int SYNC_STAGES  = 2,
   parameter int PULSE_PERIOD = 1000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [TS_W-1:0]   time_in,
   input  logic              evt_in,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   output logic [WORD_W-1:0] rd_data
);
   if (TS_W != 2 * WORD_W) begin : g_bad_split
      $error("evt_stamp_unit: TS_W must equal 2*WORD_W");
   end
   if (CNT_W + STS_CNT > WORD_W) begin : g_bad_cnt_fit
      $error("evt_stamp_unit: count field does not fit in the status word");
   end

   logic [WORD_W-1:0] cfg_q;
   logic              src_int_q;
   logic              wr_cfg, wr_sts;
   logic              ext_edge, tick, evt_sel;
   logic              valid, err;
   logic [CNT_W-1:0]  cnt;
   logic [TS_W-1:0]   ts;
   logic [WORD_W-1:0] sts_word;

   assign wr_cfg = wr_en && (wr_addr == A_CFG);
   assign wr_sts = wr_en && (wr_addr == A_STS);

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q     <= '0;
         src_int_q <= 1'b0;
      end else begin
         if (wr_cfg) cfg_q <= wr_data;
         if (wr_sts) src_int_q <= wr_data[STS_SRC];
      end
   end

   evt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .din      (evt_in),
      .fall_sel (cfg_q[CFG_FALL]),
      .edge_o   (ext_edge)
   );

   evt_tick_gen #(.PERIOD(PULSE_PERIOD)) u_tick (
      .clk    (clk),
      .rst    (rst),
      .tick_o (tick)
   );

   assign evt_sel = src_int_q ? tick : ext_edge;

   evt_capture_core #(.TS_W(TS_W), .CNT_W(CNT_W)) u_core (
      .clk        (clk),
      .rst        (rst),
      .evt        (evt_sel),
      .time_in    (time_in),
      .ovw_en     (cfg_q[CFG_OVW]),
      .cnt_en     (cfg_q[CFG_START]),
      .cnt_clr    (wr_cfg | wr_sts),
      .sts_wr     (wr_sts),
      .keep_valid (wr_data[STS_VALID]),
      .keep_err   (wr_data[STS_ERR]),
      .valid_o    (valid),
      .err_o      (err),
      .cnt_o      (cnt),
      .ts_o       (ts)
   );

   always_comb begin
      sts_word = '0;
      sts_word[STS_VALID] = valid;
      sts_word[STS_ERR]   = err;
      sts_word[STS_SRC]   = src_int_q;
      sts_word[STS_CNT +: CNT_W] = cnt;
   end

   always_comb begin
      case (rd_addr)
         A_CFG:   rd_data = cfg_q;
         A_STS:   rd_data = sts_word;
         A_TS_LO: rd_data = ts[WORD_W-1:0];
         default: rd_data = ts[TS_W-1:WORD_W];
      endcase
   end

   a_r9_clear_on_write: assert property (@(posedge clk) disable iff (rst)
      (wr_cfg || wr_sts) |=> (cnt <= CNT_W'(1)));
   a_r4_source_gate: assert property (@(posedge clk) disable iff (rst)
      (!valid && !evt_sel) |=> !valid);
endmodule

// File: tb/tb_evt_stamp_unit.sv
module tb_evt_stamp_unit;
   localparam int CLK_P = 10;
   localparam int PER   = 8;
   localparam int CW    = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] tin = 32'h0001_FFE0;
   logic        evt_in = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [15:0] wr_data = 16'h0;
   logic [1:0]  rd_addr = 2'd0;
   logic [15:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) tin <= tin + 32'd1;

   evt_stamp_unit #(.CNT_W(CW), .PULSE_PERIOD(PER)) dut (
      .clk(clk), .rst(rst), .time_in(tin), .evt_in(evt_in),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // drive evt_in at a negedge; return the expected captured value
   task automatic drive_evt(input logic lvl, output logic [31:0] exp);
      @(negedge clk);
      evt_in = lvl;
      exp = tin + 32'd2;
   endtask

   function automatic logic [15:0] sts(input bit v, input bit e, input bit s, input int c);
      return 16'((c << 8) | (int'(s) << 2) | (int'(e) << 1) | int'(v));
   endfunction

   task automatic read_ts(output logic [31:0] t);
      logic [15:0] lo, hi;
      rd(2'd2, lo);
      rd(2'd3, hi);
      t = {hi, lo};
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      logic [31:0] e, ea, t1, t2;
      bit found;
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 1'b0;

      // R1 / R11 reset values on every address
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), d);
         chk("R1 reset read", {16'h0, d}, 32'h0);
      end

      // R11 config readback of full word
      wr(2'd0, 16'hA5C4);
      rd(2'd0, d);
      chk("R11 config readback", {16'h0, d}, 32'h0000_A5C4);
      wr(2'd0, 16'h0004);

      // R2 / R3: sweep of rising captures with varying gaps; falling ignored
      for (int i = 0; i < 6; i++) begin
         wr(2'd1, 16'h0000);
         drive_evt(1'b0, e);
         wait_cyc(4 + i * 3);
         rd(2'd1, d);
         chk("R3 falling ignored in rising mode", {16'h0, d}, {16'h0, sts(0, 0, 0, 0)});
         drive_evt(1'b1, e);
         wait_cyc(5);
         rd(2'd1, d);
         chk("R2 valid and count after capture", {16'h0, d}, {16'h0, sts(1, 0, 0, 1)});
         read_ts(t1);
         chk("R2 R11 captured timestamp", t1, e);
      end

      // R3 falling mode
      wr(2'd0, 16'h0005);
      wr(2'd1, 16'h0000);
      drive_evt(1'b0, e);
      wait_cyc(5);
      read_ts(t1);
      chk("R3 falling capture value", t1, e);
      wr(2'd1, 16'h0000);
      drive_evt(1'b1, ea);
      wait_cyc(5);
      rd(2'd1, d);
      chk("R3 rising ignored in falling mode", {16'h0, d}, {16'h0, sts(0, 0, 0, 0)});

      // R5 / R6 / R10 single shot without overwrite
      wr(2'd0, 16'h0004);
      drive_evt(1'b0, ea);
      wait_cyc(5);
      wr(2'd1, 16'h0000);
      drive_evt(1'b1, e);
      wait_cyc(5);
      drive_evt(1'b0, ea);
      wait_cyc(5);
      drive_evt(1'b1, ea);
      wait_cyc(5);
      read_ts(t1);
      chk("R5 timestamp kept while valid", t1, e);
      rd(2'd1, d);
      chk("R6 error raised on missed event", {16'h0, d}, {16'h0, sts(1, 1, 0, 1)});
      wr(2'd1, 16'h0003);
      rd(2'd1, d);
      chk("R6 R9 error kept, count cleared", {16'h0, d}, {16'h0, sts(1, 1, 0, 0)});
      wr(2'd1, 16'h0001);
      rd(2'd1, d);
      chk("R6 error cleared by write", {16'h0, d}, {16'h0, sts(1, 0, 0, 0)});
      wr(2'd1, 16'h0000);
      rd(2'd1, d);
      chk("R10 valid cleared", {16'h0, d}, {16'h0, sts(0, 0, 0, 0)});
      wr(2'd1, 16'h0001);
      rd(2'd1, d);
      chk("R10 write of one does not set valid", {16'h0, d}, {16'h0, sts(0, 0, 0, 0)});

      // R7 overwrite
      wr(2'd0, 16'h0006);
      drive_evt(1'b0, ea);
      wait_cyc(5);
      wr(2'd1, 16'h0000);
      drive_evt(1'b1, ea);
      wait_cyc(5);
      drive_evt(1'b0, ea);
      wait_cyc(5);
      drive_evt(1'b1, e);
      wait_cyc(5);
      read_ts(t1);
      chk("R7 timestamp replaced", t1, e);
      rd(2'd1, d);
      chk("R7 R8 status after overwrite", {16'h0, d}, {16'h0, sts(1, 1, 0, 2)});
      wr(2'd0, 16'h0006);
      rd(2'd1, d);
      chk("R9 config write clears count", {16'h0, d}, {16'h0, sts(1, 1, 0, 0)});

      // R8 no count while start bit clear
      wr(2'd0, 16'h0002);
      wr(2'd1, 16'h0000);
      for (int i = 0; i < 3; i++) begin
         drive_evt(1'b0, ea);
         wait_cyc(5);
         drive_evt(1'b1, e);
         wait_cyc(5);
      end
      read_ts(t1);
      chk("R8 captures still update timestamp", t1, e);
      rd(2'd1, d);
      chk("R8 count frozen when start bit clear", {16'h0, d[15:8]}, 32'h0);

      // R4 internal tick ignored while external selected
      wr(2'd0, 16'h0004);
      drive_evt(1'b0, ea);
      wait_cyc(5);
      wr(2'd1, 16'h0000);
      wait_cyc(3 * PER);
      rd(2'd1, d);
      chk("R4 tick ignored with external source", {16'h0, d}, {16'h0, sts(0, 0, 0, 0)});

      // R4 internal tick period
      wr(2'd1, 16'h0004);
      found = 0;
      for (int k = 0; k < 4 * PER && !found; k++) begin
         rd(2'd1, d);
         found = d[0];
      end
      read_ts(t1);
      wr(2'd1, 16'h0004);
      found = 0;
      for (int k = 0; k < 4 * PER && !found; k++) begin
         rd(2'd1, d);
         found = d[0];
      end
      chk("R4 tick capture seen", {31'h0, found}, 32'h1);
      read_ts(t2);
      chk("R4 tick spacing", t2 - t1, PER);

      // R8 saturation via overwrite captures
      wr(2'd0, 16'h0006);
      wr(2'd1, 16'h0004);
      wait_cyc(20 * PER);
      rd(2'd1, d);
      chk("R8 count saturates", {16'h0, d[15:8]}, (1 << CW) - 1);
      chk("R7 error with tick overwrite", {31'h0, d[1]}, 32'h1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule